// File: doc/BRIEF.md
# Majority-Voting Serial Receiver

This block turns an asynchronous serial input line into data words. It shares a baud-rate tick and a frame setup with a companion transmitter. The tick is a one-cycle enable from an external divider. The frame setup covers the word length, the parity mode and the number of stop bits. Each bit period is cut into a short guard window at the front, a voting window of several samples, and a guard window at the end. The bit is then decided by majority over the voting samples. A short spike on the line therefore cannot flip a bit.

Every frame is checked for a correct parity bit and for high stop bits. A frame that fails either check is dropped without notice. After a low stop bit, the receiver waits for the line to go high again before it looks for a new start bit. A good word is presented on a valid/ready push port toward a receive FIFO. A one-cycle event pulse marks each word the port takes on. The FIFO storage and any bus logic sit outside this block.

Top module: `uart_vote_rx`

## Requirements
- R1: During and right after reset, `push_valid` and `rx_event` are 0.
- R2: The line passes through a two-flop synchronizer. A high-to-low transition on the idle line starts a frame. If the start bit does not vote low, the receiver goes back to idle and emits no word, so a low spike of one tick is rejected.
- R3: Each bit period lasts 8 ticks: 1 guard tick, then 5 voting ticks, then 2 guard ticks. The bit value is the majority of the 5 voting samples. If one sample disagrees the bit keeps its value; if three disagree the bit flips.
- R4: Data bits arrive LSB first and land in `push_data[0]` upward. `cfg_len` gives the bit count. A value below 5 is treated as 5 and a value above 9 is treated as 9. Bits of `push_data` above the length are 0.
- R5: `cfg_parity` selects the parity mode: 0 = none, 1 = even, 2 = odd, 3 = none. With parity enabled, one parity bit follows the data. Even mode requires an even count of ones over data plus parity; odd mode requires an odd count. A frame with a mismatch is dropped.
- R6: `cfg_two_stop` = 1 selects two stop bits and 0 selects one. If any stop bit votes low, the frame is dropped and the receiver waits for the line to go high before hunting for a start bit. The next correct frame is still received.
- R7: A good word sets `push_valid` with the word on `push_data`. Both hold steady until a cycle with `push_ready` high.
- R8: `rx_event` pulses for one cycle each time a word is loaded into the push port, in the same cycle that `push_valid` carries the new word.
- R9: If a new word completes while the previous one is still waiting for `push_ready`, the new word replaces it and `rx_event` pulses again.
- R10: The length, parity and stop settings are captured when the start edge is detected. Changing the inputs during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Baud tick from the shared divider, one cycle wide |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 4 | Data bit count, 5 to 9 after clamping |
| cfg_parity | input | 2 | Parity mode code (0 none, 1 even, 2 odd, 3 none) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| push_ready | input | 1 | FIFO can accept a word |
| push_valid | output | 1 | A received word is waiting |
| push_data | output | 9 | Received word, LSB first, upper bits zero |
| rx_event | output | 1 | One-cycle pulse per word loaded |

## Verification
The start edge reaches the frame controller 3 clocks after the line changes: two synchronizer flops, then the edge register. The 5 voting samples of a bit therefore fall between about 6 and 25 clocks into each 32-clock bench bit period, given a tick every 4 clocks. The decision for the last stop bit comes at its eighth tick, and the word appears on the push port two registers later. That is always inside the two idle bit periods the bench leaves after each frame, so every word and drop check is made at the end of that gap. Spike windows are placed at fixed bench offsets so that they cover exactly one, or exactly three, voting samples for any phase of the tick against the start edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2,
    ST_WAIT_HIGH
  } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
  parameter int PRE_TICKS  = 1,
  parameter int VOTE_TICKS = 5,
  parameter int POST_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick_en,
  input  logic rx_bit,
  output logic bit_done,
  output logic bit_val
);

  localparam int BIT_TICKS = PRE_TICKS + VOTE_TICKS + POST_TICKS;
  localparam int CNT_W     = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam int VOTE_W    = $clog2(VOTE_TICKS + 1);
  localparam int HALF      = VOTE_TICKS / 2;

  logic [CNT_W-1:0]  tick_cnt;
  logic [VOTE_W-1:0] ones_cnt;
  logic [VOTE_W-1:0] ones_next;
  logic              in_window;
  logic              last_tick;

  always_comb begin
    in_window = (int'(tick_cnt) >= PRE_TICKS) &&
                (int'(tick_cnt) <  PRE_TICKS + VOTE_TICKS);
    last_tick = (int'(tick_cnt) == BIT_TICKS - 1);
    ones_next = ones_cnt + ((in_window && rx_bit) ? VOTE_W'(1) : VOTE_W'(0));
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      tick_cnt <= '0;
      ones_cnt <= '0;
      bit_done <= 1'b0;
      bit_val  <= 1'b1;
    end else begin
      bit_done <= 1'b0;
      if (tick_en) begin
        if (last_tick) begin
          tick_cnt <= '0;
          ones_cnt <= '0;
          bit_done <= 1'b1;
          bit_val  <= (int'(ones_next) > HALF);
        end else begin
          tick_cnt <= tick_cnt + CNT_W'(1);
          ones_cnt <= ones_next;
        end
      end
    end
  end

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int DATA_MIN = 5,
  parameter int LEN_W    = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_s,
  input  logic                bit_done,
  input  logic                bit_val,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic                sampler_active,
  output logic                word_ok,
  output logic [DATA_MAX-1:0] word,
  output logic [LEN_W-1:0]    frame_len
);

  rx_state_e           state;
  logic                rx_prev;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    len_clamped;
  parity_e             par_q;
  parity_e             par_in;
  logic                two_q;
  logic [LEN_W-1:0]    idx;
  logic [DATA_MAX-1:0] data_q;
  logic                perr_q;
  logic                ones_odd;

  always_comb begin
    if (cfg_len < LEN_W'(DATA_MIN)) begin
      len_clamped = LEN_W'(DATA_MIN);
    end else if (cfg_len > LEN_W'(DATA_MAX)) begin
      len_clamped = LEN_W'(DATA_MAX);
    end else begin
      len_clamped = cfg_len;
    end
    par_in   = (cfg_parity == 2'd3) ? PAR_NONE : parity_e'(cfg_parity);
    ones_odd = (^data_q) ^ bit_val;
    sampler_active = (state != ST_IDLE) && (state != ST_WAIT_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rx_prev <= 1'b1;
      len_q   <= LEN_W'(DATA_MAX);
      par_q   <= PAR_NONE;
      two_q   <= 1'b0;
      idx     <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      word_ok <= 1'b0;
    end else begin
      rx_prev <= rx_s;
      word_ok <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rx_prev && !rx_s) begin
            state  <= ST_START;
            len_q  <= len_clamped;
            par_q  <= par_in;
            two_q  <= cfg_two_stop;
            idx    <= '0;
            data_q <= '0;
            perr_q <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_done) begin
            state <= bit_val ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            data_q[idx] <= bit_val;
            if (idx == len_q - LEN_W'(1)) begin
              state <= (par_q == PAR_NONE) ? ST_STOP1 : ST_PARITY;
            end else begin
              idx <= idx + LEN_W'(1);
            end
          end
        end
        ST_PARITY: begin
          if (bit_done) begin
            perr_q <= (par_q == PAR_EVEN) ? ones_odd : !ones_odd;
            state  <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (bit_done) begin
            if (!bit_val) begin
              state <= ST_WAIT_HIGH;
            end else if (two_q) begin
              state <= ST_STOP2;
            end else begin
              word_ok <= !perr_q;
              state   <= ST_IDLE;
            end
          end
        end
        ST_STOP2: begin
          if (bit_done) begin
            if (!bit_val) begin
              state <= ST_WAIT_HIGH;
            end else begin
              word_ok <= !perr_q;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WAIT_HIGH: begin
          if (rx_s) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign word      = data_q;
  assign frame_len = len_q;

endmodule

// File: rtl/rx_push_port.sv
module rx_push_port #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             push_ready,
  output logic             push_valid,
  output logic [WIDTH-1:0] push_data,
  output logic             rx_event
);

  always_ff @(posedge clk) begin
    if (rst) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      rx_event   <= 1'b0;
    end else begin
      rx_event <= load;
      if (load) begin
        push_valid <= 1'b1;
        push_data  <= load_data;
      end else if (push_valid && push_ready) begin
        push_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int DATA_MAX    = 9,
  parameter int DATA_MIN    = 5,
  parameter int PRE_TICKS   = 1,
  parameter int VOTE_TICKS  = 5,
  parameter int POST_TICKS  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                rx_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                push_ready,
  output logic                push_valid,
  output logic [DATA_MAX-1:0] push_data,
  output logic                rx_event
);

  logic                rx_s;
  logic                sampler_active;
  logic                bit_done;
  logic                bit_val;
  logic                word_ok;
  logic [DATA_MAX-1:0] word;
  logic [LEN_W-1:0]    frame_len;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rx_s)
  );

  rx_bit_sampler #(
    .PRE_TICKS  (PRE_TICKS),
    .VOTE_TICKS (VOTE_TICKS),
    .POST_TICKS (POST_TICKS)
  ) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .active   (sampler_active),
    .tick_en  (tick_en),
    .rx_bit   (rx_s),
    .bit_done (bit_done),
    .bit_val  (bit_val)
  );

  rx_frame_ctrl #(
    .DATA_MAX (DATA_MAX),
    .DATA_MIN (DATA_MIN),
    .LEN_W    (LEN_W)
  ) u_frame (
    .clk            (clk),
    .rst            (rst),
    .rx_s           (rx_s),
    .bit_done       (bit_done),
    .bit_val        (bit_val),
    .cfg_len        (cfg_len),
    .cfg_parity     (cfg_parity),
    .cfg_two_stop   (cfg_two_stop),
    .sampler_active (sampler_active),
    .word_ok        (word_ok),
    .word           (word),
    .frame_len      (frame_len)
  );

  rx_push_port #(.WIDTH(DATA_MAX)) u_push (
    .clk        (clk),
    .rst        (rst),
    .load       (word_ok),
    .load_data  (word),
    .push_ready (push_ready),
    .push_valid (push_valid),
    .push_data  (push_data),
    .rx_event   (rx_event)
  );

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
  parameter int DATA_MAX = 9,
  parameter int LEN_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                bit_done,
  input logic                word_ok,
  input logic                push_ready,
  input logic                push_valid,
  input logic [DATA_MAX-1:0] push_data,
  input logic                rx_event,
  input logic [LEN_W-1:0]    frame_len
);

  // R8
  event_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_event |-> push_valid);

  // R8
  rise_has_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(push_valid) |-> rx_event);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready) |=> push_valid);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready && !word_ok) |=> $stable(push_data));

  // R3
  bit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    bit_done |-> $past(tick_en));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rx_event |-> ((push_data >> frame_len) == '0));

endmodule

bind uart_vote_rx uart_vote_rx_chk #(
  .DATA_MAX (DATA_MAX),
  .LEN_W    (LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .bit_done   (bit_done),
  .word_ok    (word_ok),
  .push_ready (push_ready),
  .push_valid (push_valid),
  .push_data  (push_data),
  .rx_event   (rx_event),
  .frame_len  (frame_len)
);

// File: tb/tb_uart_vote_rx.sv
`timescale 1ns/1ps
module tb_uart_vote_rx;

  localparam int TICK_DIV = 4;
  localparam int BP       = 8 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en;
  logic       rx_in = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       push_ready = 1'b1;
  logic       push_valid;
  logic [8:0] push_data;
  logic       rx_event;

  int total = 0;
  int bad = 0;
  int n_words = 0;
  int n_events = 0;
  logic [8:0] last_word = '0;
  logic [1:0] div_cnt;
  bit done = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick_en <= 1'b0;
    end else begin
      div_cnt <= div_cnt + 2'd1;
      tick_en <= (div_cnt == 2'(TICK_DIV - 1));
    end
  end

  uart_vote_rx dut (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .rx_in        (rx_in),
    .cfg_len      (cfg_len),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .push_ready   (push_ready),
    .push_valid   (push_valid),
    .push_data    (push_data),
    .rx_event     (rx_event)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (push_valid && push_ready) begin
        n_words++;
        last_word = push_data;
      end
      if (rx_event) n_events++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int gl_start, input int gl_len);
    for (int c = 0; c < BP; c++) begin
      rx_in = (c >= gl_start && c < gl_start + gl_len) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int len, input int par,
                            input int nstop, input bit bad_par, input bit bad_s1,
                            input bit bad_s2, input int gbit, input int glen,
                            input bit mid_cfg);
    logic [8:0] m;
    logic p;
    int gs;
    m  = 9'((1 << len) - 1);
    p  = ^(d & m);
    gs = (glen >= 12) ? 10 : 14;
    drive_bit(1'b0, 0, 0);
    if (mid_cfg) begin
      cfg_len    = 4'd5;
      cfg_parity = 2'd1;
    end
    for (int i = 0; i < len; i++) begin
      drive_bit(d[i], gs, (i == gbit) ? glen : 0);
    end
    if (par != 0) drive_bit(((par == 1) ? p : ~p) ^ bad_par, 0, 0);
    drive_bit(~bad_s1, 0, 0);
    if (nstop == 2) drive_bit(~bad_s2, 0, 0);
    rx_in = 1'b1;
    repeat (2 * BP) @(negedge clk);
  endtask

  task automatic frame_check(input logic [8:0] d, input int len, input int par,
                             input int nstop, input bit bad_par, input bit bad_s1,
                             input bit bad_s2, input int gbit, input int glen,
                             input bit want, input logic [8:0] want_val,
                             input string req);
    int w0;
    int e0;
    w0 = n_words;
    e0 = n_events;
    send_frame(d, len, par, nstop, bad_par, bad_s1, bad_s2, gbit, glen, 1'b0);
    check(n_words == w0 + int'(want), req, n_words - w0, int'(want));
    check(n_events == e0 + int'(want), {req, " R8 event"}, n_events - e0, int'(want));
    if (want) check(last_word == want_val, req, last_word, want_val);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(push_valid == 1'b0, "R1 valid", push_valid, 0);
    check(rx_event == 1'b0, "R1 event", rx_event, 0);
    rst = 1'b0;
    repeat (3 * BP) @(negedge clk);

    // R4 R5 R6 R7 R8: sweep of length, parity, stop count and patterns
    for (int len = 5; len <= 9; len++) begin
      for (int par = 0; par <= 2; par++) begin
        for (int ns = 1; ns <= 2; ns++) begin
          for (int pat = 0; pat < 4; pat++) begin
            logic [8:0] d;
            logic [8:0] m;
            m = 9'((1 << len) - 1);
            case (pat)
              0: d = 9'h000;
              1: d = 9'h1FF;
              2: d = 9'h155;
              default: d = 9'((len * 37 + par * 11 + ns * 5) & 'h1FF);
            endcase
            cfg_len      = 4'(len);
            cfg_parity   = 2'(par);
            cfg_two_stop = (ns == 2);
            frame_check(d, len, par, ns, 0, 0, 0, -1, 0, 1'b1, d & m, "R4 sweep");
          end
        end
      end
    end

    // R5: parity errors in even and odd mode
    cfg_len = 4'd8; cfg_two_stop = 1'b0;
    cfg_parity = 2'd1;
    frame_check(9'h0A5, 8, 1, 1, 1, 0, 0, -1, 0, 1'b0, 9'h0, "R5 even error");
    cfg_parity = 2'd2;
    frame_check(9'h0A4, 8, 2, 1, 1, 0, 0, -1, 0, 1'b0, 9'h0, "R5 odd error");
    // R5: code 3 acts as no parity
    cfg_parity = 2'd3;
    frame_check(9'h03C, 8, 0, 1, 0, 0, 0, -1, 0, 1'b1, 9'h03C, "R5 code3");

    // R6: low first stop bit dropped, then next frame accepted
    cfg_parity = 2'd0;
    frame_check(9'h05A, 8, 0, 1, 0, 1, 0, -1, 0, 1'b0, 9'h0, "R6 stop1 low");
    frame_check(9'h0C3, 8, 0, 1, 0, 0, 0, -1, 0, 1'b1, 9'h0C3, "R6 recover");
    cfg_two_stop = 1'b1;
    frame_check(9'h011, 8, 0, 2, 0, 0, 1, -1, 0, 1'b0, 9'h0, "R6 stop2 low");
    frame_check(9'h0EE, 8, 0, 2, 0, 0, 0, -1, 0, 1'b1, 9'h0EE, "R6 two stop ok");
    cfg_two_stop = 1'b0;

    // R3: one disagreeing sample keeps the bit, three flip it
    frame_check(9'h0F0, 8, 0, 1, 0, 0, 0, 2, 4, 1'b1, 9'h0F0, "R3 one sample");
    frame_check(9'h0F0, 8, 0, 1, 0, 0, 0, 2, 12, 1'b1, 9'h0F4, "R3 three samples");

    // R2: short low spike on idle line, no word
    begin
      int w0;
      w0 = n_words;
      rx_in = 1'b0;
      repeat (TICK_DIV) @(negedge clk);
      rx_in = 1'b1;
      repeat (3 * BP) @(negedge clk);
      check(n_words == w0, "R2 spike", n_words - w0, 0);
    end
    frame_check(9'h081, 8, 0, 1, 0, 0, 0, -1, 0, 1'b1, 9'h081, "R2 after spike");

    // R4: clamping of out-of-range length
    cfg_len = 4'd12;
    frame_check(9'h1AB, 9, 0, 1, 0, 0, 0, -1, 0, 1'b1, 9'h1AB, "R4 clamp high");
    cfg_len = 4'd2;
    frame_check(9'h015, 5, 0, 1, 0, 0, 0, -1, 0, 1'b1, 9'h015, "R4 clamp low");

    // R10: settings changed after the start bit do not affect the frame
    begin
      int w0;
      w0 = n_words;
      cfg_len = 4'd8; cfg_parity = 2'd0;
      send_frame(9'h0B7, 8, 0, 1, 0, 0, 0, -1, 0, 1'b1);
      check(n_words == w0 + 1, "R10 count", n_words - w0, 1);
      check(last_word == 9'h0B7, "R10 word", last_word, 9'h0B7);
      cfg_parity = 2'd0;
    end

    // R7 R9: hold while not ready, newer word replaces pending one
    begin
      int w0;
      int e0;
      cfg_len = 4'd8;
      @(posedge clk); #1 push_ready = 1'b0;
      w0 = n_words;
      e0 = n_events;
      send_frame(9'h012, 8, 0, 1, 0, 0, 0, -1, 0, 1'b0);
      check(push_valid == 1'b1, "R7 held", push_valid, 1);
      check(push_data == 9'h012, "R7 data", push_data, 9'h012);
      send_frame(9'h034, 8, 0, 1, 0, 0, 0, -1, 0, 1'b0);
      check(push_data == 9'h034, "R9 replace", push_data, 9'h034);
      check(n_events == e0 + 2, "R9 events", n_events - e0, 2);
      check(n_words == w0, "R7 no handshake", n_words - w0, 0);
      @(posedge clk); #1 push_ready = 1'b1;
      repeat (3) @(negedge clk);
      check(n_words == w0 + 1, "R7 taken", n_words - w0, 1);
      check(last_word == 9'h034, "R9 taken word", last_word, 9'h034);
      check(push_valid == 1'b0, "R7 cleared", push_valid, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule